// File: doc/BRIEF.md
# Code-Section Performance Counter Unit

This block times software. A processor marks the entry and exit of chosen code sections with single writes to a small register window. For each section the unit keeps a 64-bit count of the clock cycles spent inside the section and a 32-bit count of how many times the section was entered. A master slot counts the whole measurement period with its own cycle and entry counters. No section can count unless the master is running, so every section total is a fraction of the master total.

Each write selects a command by its word offset. The write data is never looked at, so one store instruction marks a boundary. Counter values are read back through the same window, with one cycle of read latency. Each slot (the master at slot 0, sections at slots 1 to `NUM_SECTIONS`) holds one two-state machine. `SEC_IDLE` moves to `SEC_RUN` on the *launch* transition, which is a start write while the gate is open. The master's gate is always open, and a section's gate is the master's `SEC_RUN`. `SEC_RUN` returns to `SEC_IDLE` on the *halt* transition, which is a stop write to the slot or a master stop.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset every counter reads zero, every slot is in `SEC_IDLE`, and `rd_data` is zero.
- R2: A write to offset 1 launches the master and a write to offset 0 halts it. The master cycle counter grows by one for each clock edge that finds the master in `SEC_RUN`. The master entry counter grows by one on each launch.
- R3: For a section n in 1..`NUM_SECTIONS`, a write to offset 4n+1 launches it and a write to 4n halts it. Its cycle counter grows by one for each edge that finds it in `SEC_RUN`, wrapping modulo 2^64 with no flag. `wr_data` has no effect on any command.
- R4: A section start written while the master is idle is ignored. A master halt puts every section into `SEC_IDLE` at the same edge.
- R5: A section's entry counter grows by one on each launch, wrapping modulo 2^32. A start write to a section already in `SEC_RUN` changes neither of its counters.
- R6: With `rd_en` high at an edge, `rd_data` after that edge holds the pre-edge value at offset 4n+k: k=0 cycle count bits 31:0, k=1 bits 63:32, k=2 entry count, k=3 zero. With `rd_en` low, `rd_data` is zero after the edge.
- R7: A write to offset 3 zeroes every cycle and entry counter at that edge and leaves every slot's state unchanged.
- R8: Writes to slots above `NUM_SECTIONS`, and writes to offsets 4n+2 or 4n+3 for n ≥ 1, change nothing. Reads of slots above `NUM_SECTIONS` return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word offset of the access |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | DATA_W | Write data, ignored |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |

## Verification
A slot whose state disagrees with the commands shows up on the next read of its cycle counter. The count either stalls or keeps climbing when it should not, and the error grows by one every cycle. A missed or doubled launch changes the entry count, which is visible at once on a read of offset 4n+2. A mis-decoded offset returns a wrong or non-zero word on the first read after the access. The bench keeps a behavioural model of all slots and compares `rd_data` with it on every clock, so a divergence is reported at most one cycle after the read that exposes it.

// File: rtl/perf_pkg.sv
package perf_pkg;
    localparam int TIME_W = 64;
    localparam int OCC_W  = 32;
    localparam int SUB_W  = 2;

    // Low two bits of a word offset: command on write, field on read
    typedef enum logic [SUB_W-1:0] {
        SUB_STOP_LO  = 2'd0,
        SUB_START_HI = 2'd1,
        SUB_OCC      = 2'd2,
        SUB_CLEAR    = 2'd3
    } sub_e;

    typedef enum logic {
        SEC_IDLE = 1'b0,
        SEC_RUN  = 1'b1
    } sec_state_e;
endpackage

// File: rtl/perf_section.sv
module perf_section
    import perf_pkg::*;
#(
    parameter int TW = TIME_W,
    parameter int OW = OCC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          clear_i,
    input  logic          gate_i,
    output logic          active_o,
    output logic [TW-1:0] time_o,
    output logic [OW-1:0] occ_o
);
    sec_state_e state_q, state_d;
    logic       launch;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEC_IDLE: if (start_i && gate_i) state_d = SEC_RUN;
            SEC_RUN:  if (stop_i)            state_d = SEC_IDLE;
            default:                         state_d = SEC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEC_IDLE;
        else        state_q <= state_d;
    end

    assign launch   = (state_q == SEC_IDLE) && (state_d == SEC_RUN);
    assign active_o = (state_q == SEC_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_o <= '0;
            occ_o  <= '0;
        end else if (clear_i) begin
            time_o <= '0;
            occ_o  <= '0;
        end else begin
            if (active_o && gate_i) time_o <= time_o + TW'(1);
            if (launch)             occ_o  <= occ_o + OW'(1);
        end
    end
endmodule

// File: rtl/perf_decode.sv
module perf_decode
    import perf_pkg::*;
#(
    parameter int NUM_SECTIONS = 3,
    parameter int ADDR_W       = 5
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    output logic [NUM_SECTIONS:0] start_o,
    output logic [NUM_SECTIONS:0] stop_o,
    output logic                  clear_o
);
    localparam int SLOT_W = ADDR_W - SUB_W;

    logic [SLOT_W-1:0] slot;
    sub_e              sub;
    logic              master_hit;
    logic              halt_all;

    assign slot       = addr[ADDR_W-1:SUB_W];
    assign sub        = sub_e'(addr[SUB_W-1:0]);
    assign master_hit = wr_en && (slot == '0);
    assign halt_all   = master_hit && (sub == SUB_STOP_LO);
    assign clear_o    = master_hit && (sub == SUB_CLEAR);

    generate
        for (genvar s = 0; s <= NUM_SECTIONS; s++) begin : g_slot
            logic hit;
            assign hit        = wr_en && (slot == SLOT_W'(s));
            assign start_o[s] = hit && (sub == SUB_START_HI);
            if (s == 0) begin : g_master
                assign stop_o[s] = halt_all;
            end else begin : g_sec
                assign stop_o[s] = (hit && (sub == SUB_STOP_LO)) || halt_all;
            end
        end
    endgenerate
endmodule

// File: rtl/perf_readmux.sv
module perf_readmux
    import perf_pkg::*;
#(
    parameter int NUM_SECTIONS = 3,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_SECTIONS:0][TIME_W-1:0]   time_v,
    input  logic [NUM_SECTIONS:0][OCC_W-1:0]    occ_v,
    output logic [DATA_W-1:0]                   rd_data
);
    localparam int SLOT_W = ADDR_W - SUB_W;

    logic [SLOT_W-1:0] slot;
    sub_e              sub;
    logic [DATA_W-1:0] word;

    assign slot = addr[ADDR_W-1:SUB_W];
    assign sub  = sub_e'(addr[SUB_W-1:0]);

    always_comb begin
        word = '0;
        for (int s = 0; s <= NUM_SECTIONS; s++) begin
            if (slot == SLOT_W'(s)) begin
                unique case (sub)
                    SUB_STOP_LO:  word = DATA_W'(time_v[s]);
                    SUB_START_HI: word = DATA_W'(time_v[s] >> DATA_W);
                    SUB_OCC:      word = DATA_W'(occ_v[s]);
                    SUB_CLEAR:    word = '0;
                    default:      word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_en ? word : '0;
    end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import perf_pkg::*;
#(
    parameter int NUM_SECTIONS = 3,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_SECTIONS:0]              start_v;
    logic [NUM_SECTIONS:0]              stop_v;
    logic [NUM_SECTIONS:0]              act_v;
    logic [NUM_SECTIONS:0][TIME_W-1:0]  time_v;
    logic [NUM_SECTIONS:0][OCC_W-1:0]   occ_v;
    logic                               clear;
    logic                               wr_data_unused;

    // Commands are carried by the offset alone
    assign wr_data_unused = ^wr_data;

    perf_decode #(
        .NUM_SECTIONS(NUM_SECTIONS),
        .ADDR_W      (ADDR_W)
    ) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .start_o(start_v),
        .stop_o (stop_v),
        .clear_o(clear)
    );

    generate
        for (genvar g = 0; g <= NUM_SECTIONS; g++) begin : g_ctr
            logic gate;
            if (g == 0) begin : g_master
                assign gate = 1'b1;
            end else begin : g_sec
                assign gate = act_v[0];
            end
            perf_section #(
                .TW(TIME_W),
                .OW(OCC_W)
            ) u_sec (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (start_v[g]),
                .stop_i  (stop_v[g]),
                .clear_i (clear),
                .gate_i  (gate),
                .active_o(act_v[g]),
                .time_o  (time_v[g]),
                .occ_o   (occ_v[g])
            );
        end
    endgenerate

    perf_readmux #(
        .NUM_SECTIONS(NUM_SECTIONS),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W)
    ) u_read (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .addr   (addr),
        .time_v (time_v),
        .occ_v  (occ_v),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/perf_counter_unit_chk.sv
module perf_counter_unit_chk
    import perf_pkg::*;
#(
    parameter int NUM_SECTIONS = 3,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 32
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [ADDR_W-1:0]                  addr,
    input logic                               wr_en,
    input logic                               rd_en,
    input logic [DATA_W-1:0]                  rd_data,
    input logic [NUM_SECTIONS:0]              act_v,
    input logic [NUM_SECTIONS:0][TIME_W-1:0]  time_v,
    input logic [NUM_SECTIONS:0][OCC_W-1:0]   occ_v
);
    logic clr_hit;
    logic far_slot;

    assign clr_hit  = wr_en && (addr == ADDR_W'(3));
    assign far_slot = int'(addr[ADDR_W-1:SUB_W]) > NUM_SECTIONS;

    assert_idle_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    assert_far_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && far_slot) |=> (rd_data == '0));

    assert_far_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && far_slot) |=> $stable(act_v));

    generate
        for (genvar s = 0; s <= NUM_SECTIONS; s++) begin : g_chk
            assert_time_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !clr_hit |=> (time_v[s] == $past(time_v[s]) + TIME_W'($past(act_v[s]))));

            assert_occ_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !clr_hit |=> (occ_v[s] == $past(occ_v[s]) + OCC_W'($rose(act_v[s]))));

            assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
                clr_hit |=> ((time_v[s] == '0) && (occ_v[s] == '0)));

            if (s > 0) begin : g_sec
                assert_gated_by_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    act_v[s] |-> act_v[0]);
            end
        end
    endgenerate
endmodule

bind perf_counter_unit perf_counter_unit_chk #(
    .NUM_SECTIONS(NUM_SECTIONS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .act_v  (act_v),
    .time_v (time_v),
    .occ_v  (occ_v)
);

// File: tb/perf_counter_unit_tb.sv
module perf_counter_unit_tb;
    localparam int N  = 3;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural reference state, slots 0..7
    bit              m_act  [0:7];
    longint unsigned m_time [0:7];
    int unsigned     m_occ  [0:7];
    logic [31:0]     m_rd = '0;

    always #4 clk = ~clk;

    perf_counter_unit #(.NUM_SECTIONS(N), .ADDR_W(AW), .DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    always @(posedge clk) begin : model
        int slot, sub;
        slot = int'(addr) >> 2;
        sub  = int'(addr) & 3;
        if (!rst_n) begin
            m_rd = '0;
            for (int s = 0; s < 8; s++) begin
                m_act[s] = 1'b0; m_time[s] = 0; m_occ[s] = 0;
            end
        end else begin
            m_rd = '0;
            if (rd_en && slot <= N) begin
                if (sub == 0)      m_rd = m_time[slot][31:0];
                else if (sub == 1) m_rd = m_time[slot][63:32];
                else if (sub == 2) m_rd = m_occ[slot];
            end
            for (int s = 0; s <= N; s++) if (m_act[s]) m_time[s]++;
            if (wr_en) begin
                if (addr == 3) begin
                    for (int s = 0; s <= N; s++) begin m_time[s] = 0; m_occ[s] = 0; end
                end else if (slot == 0 && sub == 1) begin
                    if (!m_act[0]) begin m_act[0] = 1'b1; m_occ[0]++; end
                end else if (slot == 0 && sub == 0) begin
                    for (int s = 0; s <= N; s++) m_act[s] = 1'b0;
                end else if (slot >= 1 && slot <= N && sub == 1) begin
                    if (m_act[0] && !m_act[slot]) begin m_act[slot] = 1'b1; m_occ[slot]++; end
                end else if (slot >= 1 && slot <= N && sub == 0) begin
                    m_act[slot] = 1'b0;
                end
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rd_data !== m_rd) begin
                errors++;
                $display("FAIL %s model compare: actual=%h expected=%h", cur_req, rd_data, m_rd);
            end
        end
    end

    task automatic wr(input int a, input string req);
        cur_req = req;
        addr = AW'(a); wr_data = $urandom; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_hand(input int a, input logic [31:0] exp, input string req);
        cur_req = req;
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s read addr=%0d: actual=%h expected=%h", req, a, rd_data, exp);
        end
    endtask

    task automatic rd_model(input int a, input string req);
        cur_req = req;
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rd_data !== 32'd0) begin
            errors++;
            $display("FAIL R1 reset rd_data: actual=%h expected=%h", rd_data, 32'd0);
        end
        rd_hand(0, 0, "R1");
        rd_hand(6, 0, "R1");

        // R4: section start while master idle is ignored
        wr(5, "R4");
        idle(4);
        rd_hand(4, 0, "R4");
        rd_hand(6, 0, "R4");

        // R2: master timing and entry count
        wr(1, "R2");
        idle(10);
        rd_hand(0, 10, "R2");
        rd_hand(1, 0, "R2");
        rd_hand(2, 1, "R2");
        wr(1, "R2");
        rd_hand(2, 1, "R2");

        // R3 / R5: section 1 timing and entries
        wr(5, "R3");
        idle(6);
        rd_hand(4, 6, "R3");
        rd_hand(6, 1, "R5");
        wr(5, "R5");
        rd_hand(6, 1, "R5");
        rd_model(4, "R5");
        wr(9, "R3");
        wr(13, "R3");
        idle(5);
        wr(8, "R3");
        idle(3);
        rd_model(8, "R3");
        rd_model(10, "R3");
        rd_model(12, "R3");
        rd_model(14, "R3");

        // R7: clear keeps states
        wr(3, "R7");
        rd_hand(0, 0, "R7");
        rd_hand(2, 0, "R7");
        rd_hand(4, 2, "R7");

        // R4: master halt stops sections; start while idle ignored
        wr(0, "R4");
        idle(3);
        rd_model(4, "R4");
        rd_model(12, "R4");
        wr(5, "R4");
        rd_hand(6, 0, "R4");
        wr(1, "R4");
        idle(4);
        rd_model(4, "R4");
        rd_model(0, "R4");

        // R8: far slots and spare offsets
        wr(17, "R8");
        wr(29, "R8");
        wr(6, "R8");
        wr(7, "R8");
        rd_hand(16, 0, "R8");
        rd_hand(18, 0, "R8");
        rd_hand(29, 0, "R8");
        rd_hand(3, 0, "R6");
        rd_model(6, "R8");

        // R6: full window sweep
        wr(5, "R6");
        idle(2);
        for (int a = 0; a < 32; a++) rd_model(a, "R6");
        idle(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule